// File: doc/BRIEF.md
# Sparse-Graph Associative Recall Engine

This block holds a small set of binary images and recovers the closest one from a damaged copy. Each of its N bipolar neurons (bit 1 stands for +1, bit 0 for -1) is wired to a fixed list of D neighbours drawn from an expander-style graph, not to every other neuron. The weight on each edge is the outer-product sum over the stored images. For N = 256 and D = 20 this uses well under a tenth of the links a full N x N crossbar would need. With the default 16 x 16 image and two stored images, a probe with about a fifth of its bits flipped is expected to settle on the matching image within a few sweeps.

The images and the probe are written one row at a time through two valid/ready load streams. Both streams accept beats only while the engine is idle. A start strobe launches recall, which runs in whole sweeps. A sweep visits every neuron, and for each neuron it visits every neighbour, one neighbour per clock. Recall ends on the first sweep that changes no neuron, or when a sweep budget runs out. The engine then pulses done, reports whether it converged, and streams the final image out row by row on a valid/ready result port. That port honours back-pressure: a beat is held unchanged for as long as ready is low.

Top module: `hop_assoc_mem`

## Requirements
- R1: After reset, busy, done, converged and res_valid are 0, and pat_ready and prb_ready are 1.
- R2: A pattern beat (pat_valid and pat_ready both high) writes pat_data into row pat_row of stored image pat_slot. Bit c of a row is neuron row*SIDE + c.
- R3: A probe beat (prb_valid and prb_ready both high) writes prb_data into row prb_row of the neuron state, using the same bit mapping as R2.
- R4: Neighbour k (k = 0..D-1) of neuron i is neuron (i + (2k+1)(k+1)) mod N. Edge (i,j) carries the weight sum over stored images of x_i*x_j. The field of neuron i is the sum over its D neighbours of weight times the current state of j.
- R5: The update is synchronous. Every neuron in a sweep sees the state from the end of the previous sweep. A neuron becomes 1 when its field is at least zero, so ties resolve to 1, and becomes 0 otherwise.
- R6: When a sweep changes no neuron, recall stops with converged = 1.
- R7: Recall also stops after max_sweeps sweeps, where a value of 0 counts as 1. If the last of these sweeps changed a neuron, converged = 0.
- R8: done is a one-cycle pulse. It is high in the cycle that follows clock edge S*N*D, counted from the edge that samples start, where S is the number of sweeps run.
- R9: The result stream starts in the same cycle as done. It sends SIDE rows, row 0 first, with res_last set on the final row. A beat stays valid and unchanged while res_ready is low. After the last beat is taken, the engine returns to idle.
- R10: While busy, pat_ready and prb_ready are 0, and start, pattern beats and probe beats have no effect on the result.
- R11: A start taken while idle clears converged and raises busy on the next cycle. The converged value is then held through idle until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pat_valid | input | 1 | Pattern beat valid |
| pat_ready | output | 1 | Pattern beat accepted (idle) |
| pat_slot | input | 1 | Stored image selected |
| pat_row | input | log2(SIDE) | Row written |
| pat_data | input | SIDE | Row bits |
| prb_valid | input | 1 | Probe beat valid |
| prb_ready | output | 1 | Probe beat accepted (idle) |
| prb_row | input | log2(SIDE) | Probe row written |
| prb_data | input | SIDE | Probe row bits |
| start | input | 1 | Launch recall when idle |
| max_sweeps | input | SW | Sweep budget, sampled at start |
| busy | output | 1 | Recall or readout in progress |
| done | output | 1 | One-cycle end-of-recall pulse |
| converged | output | 1 | Last recall ended on an unchanged sweep |
| res_valid | output | 1 | Result beat valid |
| res_ready | input | 1 | Result beat taken |
| res_row | output | log2(SIDE) | Row index of the result beat |
| res_data | output | SIDE | Result row bits |
| res_last | output | 1 | Final result row |

## Verification
The bench works out the number of sweeps S from its own arithmetic model of the sweep rule. It then expects done exactly S*N*D edges after the start edge. It counts rising edges from the start edge and samples done, converged and the result signals on the falling edge that follows, so every reading falls one full half-period after the register that drives it. Result beats are read on falling edges. Ready is held low for several edges at a time so that the held beat can be compared against itself. The first beat is due in the same cycle as done.

// File: rtl/hop_pkg.sv
package hop_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_OUT} hop_state_e;

  // distance from a neuron to its k-th graph neighbour (before mod N)
  function automatic int unsigned nbr_offset(input int unsigned k);
    return (2 * k + 1) * (k + 1);
  endfunction
endpackage

// File: rtl/hop_sched.sv
module hop_sched #(
  parameter int N = 256,
  parameter int D = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 run,
  output logic [$clog2(N)-1:0] nrn_idx,
  output logic [$clog2(D)-1:0] tap_idx,
  output logic                 tap_last,
  output logic                 sweep_last
);
  localparam int LOGN = $clog2(N);
  localparam int LOGK = $clog2(D);

  assign tap_last   = (tap_idx == LOGK'(D - 1));
  assign sweep_last = tap_last && (nrn_idx == LOGN'(N - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nrn_idx <= '0;
      tap_idx <= '0;
    end else if (clear) begin
      nrn_idx <= '0;
      tap_idx <= '0;
    end else if (run) begin
      if (tap_last) begin
        tap_idx <= '0;
        nrn_idx <= nrn_idx + 1'b1;
      end else begin
        tap_idx <= tap_idx + 1'b1;
      end
    end
  end

  // R4: a neuron is finished only after all D of its taps have been visited
  p_nrn_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clear && tap_last) |=> (nrn_idx == LOGN'($past(nrn_idx) + 1'b1)) && (tap_idx == '0));
endmodule

// File: rtl/hop_accum.sv
module hop_accum #(
  parameter int P = 2,
  parameter int D = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         tap_last,
  input  logic [P-1:0] agree,
  output logic         new_bit
);
  localparam int AW = $clog2(P * D + 1) + 2;
  localparam logic signed [AW-1:0] ONE = AW'(1);
  localparam logic signed [AW-1:0] LIM = AW'(P * D);

  logic signed [AW-1:0] acc_q, step, total;

  always_comb begin
    step = '0;
    for (int p = 0; p < P; p++) begin
      step = agree[p] ? step + ONE : step - ONE;
    end
    total   = acc_q + step;
    new_bit = !total[AW-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                acc_q <= '0;
    else if (!en || tap_last)  acc_q <= '0;
    else                       acc_q <= total;
  end

  // R4: the running field never exceeds P per visited edge
  p_acc_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q <= LIM) && (acc_q >= -LIM));
endmodule

// File: rtl/hop_assoc_mem.sv
module hop_assoc_mem #(
  parameter int SIDE = 16,
  parameter int D    = 20,
  parameter int P    = 2,
  parameter int SW   = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                pat_valid,
  output logic                                pat_ready,
  input  logic [((P > 1) ? $clog2(P) : 1)-1:0] pat_slot,
  input  logic [$clog2(SIDE)-1:0]             pat_row,
  input  logic [SIDE-1:0]                     pat_data,
  input  logic                                prb_valid,
  output logic                                prb_ready,
  input  logic [$clog2(SIDE)-1:0]             prb_row,
  input  logic [SIDE-1:0]                     prb_data,
  input  logic                                start,
  input  logic [SW-1:0]                       max_sweeps,
  output logic                                busy,
  output logic                                done,
  output logic                                converged,
  output logic                                res_valid,
  input  logic                                res_ready,
  output logic [$clog2(SIDE)-1:0]             res_row,
  output logic [SIDE-1:0]                     res_data,
  output logic                                res_last
);
  import hop_pkg::*;

  localparam int N    = SIDE * SIDE;
  localparam int LOGN = $clog2(N);
  localparam int LOGK = $clog2(D);
  localparam int SLW  = (P > 1) ? $clog2(P) : 1;
  localparam int RW   = $clog2(SIDE);

  hop_state_e state_q;
  logic [N-1:0] pat_q [P];
  logic [N-1:0] st_q, nxt_q, nxt_full;
  logic         chg_q, chg_now;
  logic [SW-1:0] swp_q, limit_q;

  logic [LOGN-1:0] nrn_idx, nbr_idx;
  logic [LOGK-1:0] tap_idx;
  logic            tap_last, sweep_last, new_bit, running;
  logic [P-1:0]    agree;
  logic [LOGN-1:0] off_tab [D];

  assign running   = (state_q == ST_RUN);
  assign busy      = (state_q != ST_IDLE);
  assign pat_ready = !busy;
  assign prb_ready = !busy;

  // fixed neighbour offsets of the graph
  for (genvar g = 0; g < D; g++) begin : g_off
    assign off_tab[g] = LOGN'(nbr_offset(g) % N);
  end

  assign nbr_idx = nrn_idx + off_tab[tap_idx];

  // per stored image: sign of x_i * x_j * s_j (1 means +1)
  for (genvar g = 0; g < P; g++) begin : g_img
    assign agree[g] = pat_q[g][nrn_idx] ^ pat_q[g][nbr_idx] ^ st_q[nbr_idx];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pat_q[g] <= '0;
      else if (pat_valid && pat_ready && pat_slot == SLW'(g))
        pat_q[g][int'(pat_row)*SIDE +: SIDE] <= pat_data;
    end
  end

  hop_sched #(.N(N), .D(D)) sched_i (
    .clk(clk), .rst_n(rst_n), .clear(!running), .run(running),
    .nrn_idx(nrn_idx), .tap_idx(tap_idx), .tap_last(tap_last), .sweep_last(sweep_last)
  );

  hop_accum #(.P(P), .D(D)) accum_i (
    .clk(clk), .rst_n(rst_n), .en(running), .tap_last(tap_last),
    .agree(agree), .new_bit(new_bit)
  );

  always_comb begin
    nxt_full          = nxt_q;
    nxt_full[nrn_idx] = new_bit;
    chg_now           = chg_q | (new_bit != st_q[nrn_idx]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      st_q      <= '0;
      nxt_q     <= '0;
      chg_q     <= 1'b0;
      swp_q     <= '0;
      limit_q   <= SW'(1);
      done      <= 1'b0;
      converged <= 1'b0;
      res_row   <= '0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (prb_valid) st_q[int'(prb_row)*SIDE +: SIDE] <= prb_data;
          if (start) begin
            state_q   <= ST_RUN;
            converged <= 1'b0;
            swp_q     <= '0;
            chg_q     <= 1'b0;
            limit_q   <= (max_sweeps == '0) ? SW'(1) : max_sweeps;
          end
        end
        ST_RUN: begin
          if (tap_last) begin
            nxt_q[nrn_idx] <= new_bit;
            chg_q          <= chg_now;
          end
          if (sweep_last) begin
            st_q  <= nxt_full;
            chg_q <= 1'b0;
            swp_q <= swp_q + 1'b1;
            if (!chg_now || (swp_q + 1'b1 == limit_q)) begin
              state_q   <= ST_OUT;
              done      <= 1'b1;
              converged <= !chg_now;
              res_row   <= '0;
            end
          end
        end
        ST_OUT: begin
          if (res_ready) begin
            if (res_row == RW'(SIDE - 1)) begin
              state_q <= ST_IDLE;
              res_row <= '0;
            end else begin
              res_row <= res_row + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign res_valid = (state_q == ST_OUT);
  assign res_data  = st_q[int'(res_row)*SIDE +: SIDE];
  assign res_last  = res_valid && (res_row == RW'(SIDE - 1));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_first_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (res_valid && res_row == '0));
  p_res_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_row) && $stable(res_data)));
  p_start_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !converged));
  p_conv_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(converged));
  p_state_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> $stable(st_q));
endmodule

// File: tb/hop_assoc_mem_tb.sv
module hop_assoc_mem_tb_top;
  localparam int CLK_P = 10;
  localparam int SIDE  = 8;
  localparam int D     = 6;
  localparam int P     = 2;
  localparam int SW    = 4;
  localparam int N     = SIDE * SIDE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pat_valid = 1'b0, prb_valid = 1'b0, start = 1'b0, res_ready = 1'b0;
  logic pat_slot = 1'b0;
  logic [2:0] pat_row = '0, prb_row = '0;
  logic [SIDE-1:0] pat_data = '0, prb_data = '0;
  logic [SW-1:0] max_sw = '0;
  logic pat_ready, prb_ready, busy, done, converged, res_valid, res_last;
  logic [2:0] res_row;
  logic [SIDE-1:0] res_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_P / 2) clk = ~clk;

  hop_assoc_mem #(.SIDE(SIDE), .D(D), .P(P), .SW(SW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .pat_valid(pat_valid), .pat_ready(pat_ready), .pat_slot(pat_slot),
    .pat_row(pat_row), .pat_data(pat_data),
    .prb_valid(prb_valid), .prb_ready(prb_ready), .prb_row(prb_row), .prb_data(prb_data),
    .start(start), .max_sweeps(max_sw), .busy(busy), .done(done), .converged(converged),
    .res_valid(res_valid), .res_ready(res_ready), .res_row(res_row),
    .res_data(res_data), .res_last(res_last)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt_rand();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  function automatic logic [N-1:0] rand_vec();
    return {nxt_rand(), nxt_rand()};
  endfunction

  function automatic logic [N-1:0] flips(input int f);
    logic [N-1:0] m = '0;
    while ($countones(m) < f) m[nxt_rand() % N] = 1'b1;
    return m;
  endfunction

  // R4/R5 arithmetic model of one synchronous sweep
  function automatic logic [N-1:0] sweep(input logic [N-1:0] a, input logic [N-1:0] b, input logic [N-1:0] s);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      int acc = 0;
      for (int k = 0; k < D; k++) begin
        int j = (i + (2 * k + 1) * (k + 1)) % N;
        acc += (a[i] ^ a[j] ^ s[j]) ? 1 : -1;
        acc += (b[i] ^ b[j] ^ s[j]) ? 1 : -1;
      end
      r[i] = (acc >= 0);
    end
    return r;
  endfunction

  task automatic load_all(input logic [N-1:0] a, input logic [N-1:0] b, input logic [N-1:0] pr);
    for (int r = 0; r < 2 * SIDE; r++) begin
      @(negedge clk);
      pat_valid = 1'b1;
      pat_slot  = (r >= SIDE);
      pat_row   = 3'(r % SIDE);
      pat_data  = (r >= SIDE) ? b[(r % SIDE)*SIDE +: SIDE] : a[(r % SIDE)*SIDE +: SIDE];
      @(posedge clk);
    end
    @(negedge clk);
    pat_valid = 1'b0;
    for (int r = 0; r < SIDE; r++) begin
      @(negedge clk);
      prb_valid = 1'b1;
      prb_row   = 3'(r);
      prb_data  = pr[r*SIDE +: SIDE];
      @(posedge clk);
    end
    @(negedge clk);
    prb_valid = 1'b0;
  endtask

  task automatic run_case(input logic [N-1:0] a, input logic [N-1:0] b, input logic [N-1:0] pr,
                          input int mx, input bit poke, input int bp);
    logic [N-1:0] s;
    logic [N-1:0] ns;
    int sw_cnt = 0;
    bit cv = 0;
    int lim = (mx == 0) ? 1 : mx;
    int cnt = 0;
    load_all(a, b, pr);
    s = pr;
    while (1) begin
      ns = sweep(a, b, s);
      sw_cnt++;
      if (ns == s) begin cv = 1; break; end
      s = ns;
      if (sw_cnt >= lim) break;
    end
    @(negedge clk);
    start  = 1'b1;
    max_sw = SW'(mx);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(busy && !converged, "R11 start", {busy, converged}, 2'b10);
    while (1) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      if (poke && cnt == 5) begin
        start = 1'b1; prb_valid = 1'b1; prb_row = '0; prb_data = '0;
        pat_valid = 1'b1; pat_slot = 1'b0; pat_row = '0; pat_data = '0;
        chk(!prb_ready && !pat_ready, "R10 ready", {prb_ready, pat_ready}, 2'b00);
      end else begin
        start = 1'b0; prb_valid = 1'b0; pat_valid = 1'b0;
      end
      if (done || cnt > 20 * N * D) break;
    end
    chk(cnt == sw_cnt * N * D, "R8 done timing", 64'(cnt), 64'(sw_cnt * N * D));
    chk(converged == cv, cv ? "R6 converged" : "R7 sweep limit", 64'(converged), 64'(cv));
    for (int r = 0; r < SIDE; r++) begin
      chk(res_valid && res_row == 3'(r), "R9 beat", {res_valid, res_row}, {1'b1, 3'(r)});
      chk(res_data == s[r*SIDE +: SIDE], "R3 R4 R5 result row", res_data, s[r*SIDE +: SIDE]);
      chk(res_last == (r == SIDE - 1), "R9 last", 64'(res_last), 64'(r == SIDE - 1));
      res_ready = 1'b0;
      for (int w = 0; w < bp; w++) begin
        @(posedge clk);
        @(negedge clk);
        chk(res_valid && res_row == 3'(r) && res_data == s[r*SIDE +: SIDE], "R9 hold",
            res_data, s[r*SIDE +: SIDE]);
      end
      res_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      res_ready = 1'b0;
      if (r == 0) chk(!done, "R8 pulse", 64'(done), 64'(0));
    end
    chk(!busy && !res_valid, "R9 idle after", {busy, res_valid}, 2'b00);
    repeat (3) @(negedge clk);
    chk(converged == cv, "R11 hold", 64'(converged), 64'(cv));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] a, b;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !converged && !res_valid, "R1 idle outputs",
        {busy, done, converged, res_valid}, 4'b0000);
    chk(pat_ready && prb_ready, "R1 readies", {pat_ready, prb_ready}, 2'b11);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && pat_ready && prb_ready, "R1 after release", {busy, pat_ready, prb_ready}, 3'b011);

    a = rand_vec();
    b = rand_vec();
    run_case(a, b, a ^ flips(13), 8, 0, 0);      // R2 R3 noisy first image
    run_case(a, b, b ^ flips(13), 8, 0, 2);      // noisy second image, back-pressure
    run_case(a, b, rand_vec(), 1, 0, 1);         // R7 single sweep
    run_case(a, b, rand_vec(), 0, 0, 0);         // R7 zero budget acts as one
    run_case(a, b, a, 8, 1, 0);                  // R10 stimulus while busy
    run_case({N{1'b1}}, {N{1'b1}}, rand_vec(), 8, 0, 0); // R5 tie-rich fields
    for (int c = 0; c < 4; c++) begin
      a = rand_vec();
      b = rand_vec();
      run_case(a, b, ((c % 2) ? b : a) ^ flips(6 + 2 * c), 6, 0, c);
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule